// File: doc/BRIEF.md
# Oscillator frequency measurement counter

This block measures how fast a free-running oscillator toggles, using the register clock as the time base. Software sets an enable bit in a single control/status register. The block then counts rising edges of the oscillator over a fixed number of reference clock cycles. When that window closes, it latches the edge count into a result output and raises a done flag. Firmware polls the done flag.

The oscillator is brought into the reference domain through a synchroniser, and its rising edges are detected there. After one measurement the counter stays idle. Firmware starts a fresh measurement by clearing the enable bit and setting it again. Clearing the enable bit also clears the done flag. The result value is kept until a later window closes. The register resets to 0x80. Every bit other than the enable and done bits keeps its reset value.

Top module: `osc_freq_meter`

## Requirements
- R1: After reset, the control register reads 0x00000080 and the count output is 0.
- R2: A write with bit 1 set makes bit 1 read back as 1. A write with bit 1 clear makes it read back as 0.
- R3: After a write that takes bit 1 from 0 to 1, the done flag (bit 6) reads 0 for the next WIN_CYCLES-1 cycles. It reads 1 from the WIN_CYCLES-th clock edge after the write edge onward.
- R4: The latched count equals the number of oscillator rising edges seen in the WIN_CYCLES reference cycles that follow the enabling write. For an oscillator whose period divides WIN_CYCLES, this is exactly WIN_CYCLES divided by the period. For other periods it is the floor or the ceiling of that ratio.
- R5: Once done is set and bit 1 stays 1, done stays 1 and the count output does not change. This holds even if bit 1 is written as 1 again.
- R6: A write with bit 1 clear makes done read 0 from the next cycle. The count output keeps its last latched value.
- R7: Writes to bit 6 and to all bits other than bit 1 have no effect. Those bits always read their reset values, except bit 6, which shows the done flag.
- R8: Clearing and then setting bit 1 starts a new window, and the new count replaces the old one.
- R9: With the oscillator held static, a measurement yields a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also used for the register bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Write strobe for the control register |
| regWrData | input | 32 | Write data; only bit 1 is used |
| regRdData | output | 32 | Control/status readback: bit 1 is the enable bit, bit 6 the done flag |
| oscIn | input | 1 | Oscillator to be measured, asynchronous to clk |
| measCount | output | CNT_W | Latched edge count of the last finished window |

## Verification
Some checks run on every cycle:
- done is only ever high while enable is high;
- done rises only out of a running window;
- done stays set until a clearing write;
- a clearing write drops done on the next cycle;
- the count output changes only on a latch strobe;
- the edge counter never exceeds the window length.

Other properties need a known oscillator period and appear only in the bench scenarios:
- the exact cycle on which done appears;
- the exact edge count;
- that a count is retained after a clear;
- that a second measurement gives a new value.

// File: rtl/osc_meas_pkg.sv
package osc_meas_pkg;

  typedef enum logic [1:0] {
    MEAS_IDLE = 2'd0,
    MEAS_RUN  = 2'd1,
    MEAS_HOLD = 2'd2
  } measState_t;

  // Strobes passed from the window controller to the counting datapath
  typedef struct packed {
    logic clrCount;
    logic countEn;
    logic latchResult;
  } measStrobe_t;

endpackage

// File: rtl/osc_meas_ctrl.sv
module osc_meas_ctrl
  import osc_meas_pkg::*;
#(
  parameter int WIN_CYCLES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        wrEnBit,
  output logic        enable,
  output logic        done,
  output measStrobe_t strobe
);

  localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);

  measState_t state;
  logic [WIN_W-1:0] winCnt;
  logic enReg;
  logic doneReg;
  logic startReq;
  logic stopReq;
  logic winLast;

  assign startReq = wrEn && wrEnBit && !enReg;
  assign stopReq  = wrEn && !wrEnBit;
  assign winLast  = (winCnt == WIN_LAST);

  always_comb begin
    strobe = '0;
    strobe.clrCount    = startReq;
    strobe.countEn     = (state == MEAS_RUN) && !stopReq;
    strobe.latchResult = (state == MEAS_RUN) && winLast && !stopReq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enReg <= 1'b0;
    end else if (wrEn) begin
      enReg <= wrEnBit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= MEAS_IDLE;
      winCnt <= '0;
    end else if (stopReq) begin
      state  <= MEAS_IDLE;
      winCnt <= '0;
    end else begin
      case (state)
        MEAS_IDLE: begin
          if (startReq) begin
            state  <= MEAS_RUN;
            winCnt <= '0;
          end
        end
        MEAS_RUN: begin
          if (winLast) begin
            state <= MEAS_HOLD;
          end else begin
            winCnt <= winCnt + 1'b1;
          end
        end
        MEAS_HOLD: state <= MEAS_HOLD;
        default:   state <= MEAS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneReg <= 1'b0;
    end else if (stopReq) begin
      doneReg <= 1'b0;
    end else if (strobe.latchResult) begin
      doneReg <= 1'b1;
    end
  end

  assign enable = enReg;
  assign done   = doneReg;

  // R6: done can only be observed while the enable bit is set
  assert_done_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    doneReg |-> enReg);

  // R6: a clearing write removes done on the following cycle
  assert_clear_drops_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrEnBit) |=> !doneReg);

  // R5: done is sticky until a clearing write
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (doneReg && !(wrEn && !wrEnBit)) |=> doneReg);

  // R3: done only rises at the end of a running window
  assert_done_from_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doneReg) |-> ($past(state) == MEAS_RUN));

endmodule

// File: rtl/osc_meas_datapath.sv
module osc_meas_datapath
  import osc_meas_pkg::*;
#(
  parameter int WIN_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(WIN_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oscIn,
  input  measStrobe_t      strobe,
  output logic [CNT_W-1:0] result
);

  // SYNC_STAGES flops for metastability, one more to remember the last level
  logic [SYNC_STAGES:0] syncChain;
  logic oscRise;
  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] edgeNext;
  logic [CNT_W-1:0] resultReg;

  genvar gs;
  generate
    for (gs = 0; gs <= SYNC_STAGES; gs++) begin : gSync
      if (gs == 0) begin : gFirst
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncChain[gs] <= 1'b0;
          else        syncChain[gs] <= oscIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncChain[gs] <= 1'b0;
          else        syncChain[gs] <= syncChain[gs-1];
        end
      end
    end
  endgenerate

  assign oscRise  = syncChain[SYNC_STAGES-1] && !syncChain[SYNC_STAGES];
  assign edgeNext = edgeCnt + CNT_W'(oscRise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edgeCnt <= '0;
    end else if (strobe.clrCount) begin
      edgeCnt <= '0;
    end else if (strobe.countEn) begin
      edgeCnt <= edgeNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultReg <= '0;
    end else if (strobe.latchResult) begin
      resultReg <= edgeNext;
    end
  end

  assign result = resultReg;

  // R5: the visible count moves only on a latch strobe
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.latchResult |=> $stable(resultReg));

  // R4: the edge counter never runs past the window length
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    edgeCnt <= CNT_W'(WIN_CYCLES));

endmodule

// File: rtl/osc_freq_meter.sv
module osc_freq_meter
  import osc_meas_pkg::*;
#(
  parameter int          WIN_CYCLES  = 1024,
  parameter int          SYNC_STAGES = 2,
  parameter int          DATA_W      = 32,
  parameter int          EN_BIT      = 1,
  parameter int          DONE_BIT    = 6,
  parameter logic [31:0] CTRL_RESET  = 32'h0000_0080,
  parameter int          CNT_W       = $clog2(WIN_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              oscIn,
  output logic [CNT_W-1:0]  measCount
);

  measStrobe_t strobe;
  logic enable;
  logic done;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData;

  osc_meas_ctrl #(
    .WIN_CYCLES(WIN_CYCLES)
  ) uCtrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (regWrEn),
    .wrEnBit(regWrData[EN_BIT]),
    .enable (enable),
    .done   (done),
    .strobe (strobe)
  );

  osc_meas_datapath #(
    .WIN_CYCLES (WIN_CYCLES),
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W)
  ) uPath (
    .clk   (clk),
    .rst_n (rst_n),
    .oscIn (oscIn),
    .strobe(strobe),
    .result(measCount)
  );

  // Readback: live bits at the enable and done positions, reset constants elsewhere
  genvar gb;
  generate
    for (gb = 0; gb < DATA_W; gb++) begin : gRd
      if (gb == EN_BIT) begin : gEn
        assign regRdData[gb] = enable;
      end else if (gb == DONE_BIT) begin : gDone
        assign regRdData[gb] = done;
      end else begin : gConst
        assign regRdData[gb] = CTRL_RESET[gb];
      end
    end
  endgenerate

endmodule

// File: tb/tb_osc_freq_meter.sv
module tb_osc_freq_meter;

  localparam int WIN   = 64;
  localparam int CNT_W = $clog2(WIN + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic oscIn = 1'b0;
  logic [CNT_W-1:0] measCount;

  int checks = 0;
  int fails = 0;
  int oscPeriod = 0;
  int oscPhase = 0;
  int cycles = 0;

  osc_freq_meter #(.WIN_CYCLES(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .oscIn(oscIn), .measCount(measCount)
  );

  always #5 clk = ~clk;

  // Oscillator model: period in reference cycles, 0 holds the level low
  always @(negedge clk) begin
    if (oscPeriod == 0) begin
      oscIn <= 1'b0;
      oscPhase <= 0;
    end else begin
      oscPhase <= (oscPhase + 1 >= oscPeriod) ? 0 : oscPhase + 1;
      oscIn <= (oscPhase < oscPeriod / 2);
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int expLow(int p);
    return (p == 0) ? 0 : WIN / p;
  endfunction

  function automatic int expHigh(int p);
    return (p == 0) ? 0 : (WIN + p - 1) / p;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkRange(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic writeReg(logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = '0;
  endtask

  task automatic setOsc(int p);
    oscPeriod = p;
    repeat (3 * p + 8) @(negedge clk);
  endtask

  // Enables, checks done timing, returns the latched count
  task automatic measure(output int cnt);
    writeReg(32'h2);
    repeat (WIN - 1) @(negedge clk);
    check("R3 done before window end", {31'd0, regRdData[6]}, 32'd0);
    @(negedge clk);
    check("R3 done at window end", {31'd0, regRdData[6]}, 32'd1);
    cnt = int'(measCount);
  endtask

  initial begin
    int cnt;
    int prev;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset readback", regRdData, 32'h80);
    check("R1 reset count", {{(32-CNT_W){1'b0}}, measCount}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: static oscillator
    setOsc(0);
    measure(cnt);
    check("R9 idle count", cnt, 0);
    check("R2 enable readback", regRdData, 32'hC2);

    // R8/R4: periodic oscillator, directed
    writeReg(32'h0);
    check("R2 enable cleared", regRdData, 32'h80);
    setOsc(4);
    measure(cnt);
    check("R4 R8 count period 4", cnt, expLow(4));

    // R5: rewrite of 1 does not restart, count and done hold
    prev = cnt;
    setOsc(8);
    writeReg(32'h2);
    repeat (WIN + 10) @(negedge clk);
    check("R5 done held", {31'd0, regRdData[6]}, 32'd1);
    check("R5 count held", int'(measCount), prev);

    // R7: other bits and bit 6 writes ignored
    writeReg(32'hFFFF_FFFF);
    check("R7 all-ones write", regRdData, 32'hC2);

    // R6: clear with bit 6 set in the data
    writeReg(32'h0000_0040);
    check("R6 R7 clear drops done", regRdData, 32'h80);
    check("R6 count kept", int'(measCount), prev);

    // R6: clear part way through a window aborts it
    writeReg(32'h2);
    repeat (WIN / 2) @(negedge clk);
    writeReg(32'h0);
    repeat (WIN) @(negedge clk);
    check("R6 aborted window no done", regRdData, 32'h80);
    check("R6 aborted window count kept", int'(measCount), prev);

    // Random periods
    for (int i = 0; i < 14; i++) begin
      int p;
      p = 2 + int'($urandom_range(0, 30));
      setOsc(p);
      measure(cnt);
      checkRange("R4 random period count", cnt, expLow(p), expHigh(p));
      writeReg(32'h0);
    end

    // Corner: fastest oscillator, and one edge per window
    setOsc(2);
    measure(cnt);
    check("R4 period 2 count", cnt, expLow(2));
    writeReg(32'h0);
    setOsc(WIN);
    measure(cnt);
    check("R4 period WIN count", cnt, 1);
    writeReg(32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule